// File: doc/BRIEF.md
# Configurable LUT Logic Cluster

This block is a small programmable logic cluster. It holds eight 4-input lookup tables. A set of mode bits decides how they are used. Each table can drive its own output. A pair of neighbouring tables can be joined through a 2:1 multiplexer to act as one 5-input table. A half of four tables can be reduced through a select tree to one 6-input table or one 8-to-1 multiplexer. Each of the eight outputs has a storage flop behind it. The flop captures either the cell's combinational value or a direct data bit. A per-output bit then picks the flop or the combinational path.

Truth tables and mode bits enter through a one-bit serial chain that shifts only while `cfg_en` is high. The cluster outputs are not meaningful until a full load of `CFG_W` bits has completed. The flops reset synchronously, but the configuration is kept across reset.

Top module: `lut_cluster`

## Requirements
- R1: While `cfg_en` is 1, each rising edge shifts `cfg_din` into configuration bit 0 and moves every bit up by one, so the first bit of a 156-bit load ends at bit 155. While `cfg_en` is 0, the configuration holds whatever `cfg_din` does. Layout: LUT i truth table at bits [16i+15:16i]; pair-join bits at 128..131 (pair m = LUTs 2m and 2m+1); pair-share at 132..135; half-wide at 136..137 (half h = LUTs 4h..4h+3); half-share at 138..139; flop source at 140..147; output select at 148..155.
- R2: LUT i reads `lut_in[4i+3:4i]` as an index n and yields truth table bit n.
- R3: With pair-join m set, output 2m carries `pair_sel[m]` ? LUT 2m+1 : LUT 2m. Output 2m+1 always carries LUT 2m+1.
- R4: With pair-share m set, LUT 2m+1 reads the inputs of LUT 2m. Together with pair-join this forms a 5-input function whose fifth input is `pair_sel[m]`.
- R5: Each pair's join and share bits act independently, so 4-input and 5-input use can be mixed across the cluster.
- R6: With half-share h set, all four LUTs of half h read the inputs of LUT 4h. With half-wide h set, output 4h+3 carries a 4:1 choice among the half's LUTs. `pair_sel[2h]` picks odd over even within each pair, and `pair_sel[2h+1]` picks the upper pair (LUTs 4h+2/4h+3) over the lower pair.
- R7: Half-wide without half-share gives an 8-to-1 multiplexer when each LUT holds a 2:1 mux of its own inputs.
- R8: On each rising edge without reset, flop i loads `dir_in[i]` if its source bit is 1. Otherwise it loads cell value i.
- R9: Output i shows flop i when its output-select bit is 1, and cell value i when the bit is 0.
- R10: A rising edge with `rst` high clears all eight flops to 0 and leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output flops |
| cfg_en | input | 1 | Enables configuration shifting |
| cfg_din | input | 1 | Serial configuration data |
| lut_in | input | 32 | Four inputs per LUT, LUT i at [4i+3:4i] |
| pair_sel | input | 4 | Join select per pair |
| dir_in | input | 8 | Direct data for each flop |
| cell_out | output | 8 | Cluster outputs |

## Verification
The bench aims at the select roles in the wide path. If the two select bits were swapped, an 8-to-1 selection would return a neighbouring LUT's value. It also checks that a joined pair leaves the odd output on its own LUT. A design that routed the join result there, or shared inputs in the wrong direction, would show wrong odd outputs under mixed modes. Configuration bit order is probed with a sparse load that lights one truth-table bit and one flop path; a reversed chain would light different outputs. Reset is checked to clear only the flops. A design that also cleared configuration would lose its functions after the reset pulse.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LC_K    = 4;
  localparam int LC_LUTS = 8;

  function automatic int cfg_width(input int k, input int luts);
    return luts * (2 ** k) + 2 * (luts / 2) + 2 * (luts / 4) + 2 * luts;
  endfunction
endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int W = 156
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  // configuration storage is deliberately not reset
  always_ff @(posedge clk) begin
    if (en) q <= {q[W-2:0], din};
  end

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (q[0] == $past(din)));
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int K = 4,
  localparam int D = 2 ** K
) (
  input  logic [D-1:0] tt,
  input  logic [K-1:0] a,
  output logic         y
);
  assign y = tt[a];
endmodule

// File: rtl/lc_half.sv
module lc_half #(
  parameter int K = 4,
  localparam int D = 2 ** K
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [4*K-1:0] in_bus,
  input  logic [1:0]     sel,
  input  logic [4*D-1:0] tt,
  input  logic [1:0]     fuse,
  input  logic [1:0]     share_pair,
  input  logic           wide,
  input  logic           share_half,
  output logic [3:0]     cval
);
  logic [K-1:0] eff [4];
  logic [3:0]   ly;
  logic [1:0]   pm;
  logic         q_lo, q_hi, wy;

  for (genvar j = 0; j < 4; j++) begin : g_lut
    if (j == 0) begin : g_base
      assign eff[j] = in_bus[K-1:0];
    end else if (j % 2 == 1) begin : g_odd
      assign eff[j] = share_half        ? in_bus[K-1:0] :
                      share_pair[j / 2] ? in_bus[(j-1)*K +: K] :
                                          in_bus[j*K +: K];
    end else begin : g_even
      assign eff[j] = share_half ? in_bus[K-1:0] : in_bus[j*K +: K];
    end
    lc_lut #(.K(K)) u_lut (.tt(tt[j*D +: D]), .a(eff[j]), .y(ly[j]));
  end

  for (genvar m = 0; m < 2; m++) begin : g_pair
    assign pm[m] = sel[m] ? ly[2*m+1] : ly[2*m];
  end

  // wide tree: low select picks within pairs, high select picks the pair
  assign q_lo = sel[0] ? ly[1] : ly[0];
  assign q_hi = sel[0] ? ly[3] : ly[2];
  assign wy   = sel[1] ? q_hi  : q_lo;

  assign cval[0] = fuse[0] ? pm[0] : ly[0];
  assign cval[1] = ly[1];
  assign cval[2] = fuse[1] ? pm[1] : ly[2];
  assign cval[3] = wide    ? wy    : ly[3];

  // R6
  tie_chk: assert property (@(posedge clk) disable iff (rst)
    share_half |-> (eff[1] == in_bus[K-1:0] && eff[2] == in_bus[K-1:0]
                    && eff[3] == in_bus[K-1:0]));
  // R3
  odd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    cval[1] == ly[1]);
  // R3
  fuse_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (fuse[0] && sel[0]) |-> (cval[0] == ly[1]));
  // R7
  wide_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (wide && sel == 2'b10) |-> (cval[3] == ly[2]));
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster #(
  parameter int K    = lc_pkg::LC_K,
  parameter int LUTS = lc_pkg::LC_LUTS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_en,
  input  logic            cfg_din,
  input  logic [LUTS*K-1:0] lut_in,
  input  logic [LUTS/2-1:0] pair_sel,
  input  logic [LUTS-1:0] dir_in,
  output logic [LUTS-1:0] cell_out
);
  localparam int D        = 2 ** K;
  localparam int TT_W     = LUTS * D;
  localparam int PAIRS    = LUTS / 2;
  localparam int HALVES   = LUTS / 4;
  localparam int OFF_FUSE = TT_W;
  localparam int OFF_SP   = OFF_FUSE + PAIRS;
  localparam int OFF_WIDE = OFF_SP + PAIRS;
  localparam int OFF_SH   = OFF_WIDE + HALVES;
  localparam int OFF_FF   = OFF_SH + HALVES;
  localparam int OFF_RS   = OFF_FF + LUTS;
  localparam int CFG_W    = lc_pkg::cfg_width(K, LUTS);

  logic [CFG_W-1:0]  cfg;
  logic [LUTS-1:0]   cval;
  logic [LUTS-1:0]   ff_q;
  logic [LUTS-1:0]   ff_src, rs;

  lc_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .en(cfg_en), .din(cfg_din), .q(cfg)
  );

  assign ff_src = cfg[OFF_FF +: LUTS];
  assign rs     = cfg[OFF_RS +: LUTS];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    lc_half #(.K(K)) u_half (
      .clk(clk),
      .rst(rst),
      .in_bus(lut_in[h*4*K +: 4*K]),
      .sel(pair_sel[2*h +: 2]),
      .tt(cfg[h*4*D +: 4*D]),
      .fuse(cfg[OFF_FUSE + 2*h +: 2]),
      .share_pair(cfg[OFF_SP + 2*h +: 2]),
      .wide(cfg[OFF_WIDE + h]),
      .share_half(cfg[OFF_SH + h]),
      .cval(cval[4*h +: 4])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_q <= '0;
    end else begin
      for (int i = 0; i < LUTS; i++) begin
        ff_q[i] <= ff_src[i] ? dir_in[i] : cval[i];
      end
    end
  end

  assign cell_out = (ff_q & rs) | (cval & ~rs);

  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> ((cell_out & rs) == '0));

  for (genvar i = 0; i < LUTS; i++) begin : g_chk
    // R8
    dir_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_en && rs[i] && ff_src[i]) |=> (cell_out[i] == $past(dir_in[i])));
  end
endmodule

// File: tb/sim_lut_cluster.sv
module sim_lut_cluster;
  localparam int CLK_P    = 10;
  localparam int LUTS     = 8;
  localparam int TT_W     = LUTS * 16;
  localparam int OFF_FUSE = TT_W;
  localparam int OFF_SP   = OFF_FUSE + 4;
  localparam int OFF_WIDE = OFF_SP + 4;
  localparam int OFF_SH   = OFF_WIDE + 2;
  localparam int OFF_FF   = OFF_SH + 2;
  localparam int OFF_RS   = OFF_FF + 8;
  localparam int CFG_W    = OFF_RS + 8;
  localparam int NVEC     = 16;

  // {config id, lut_in, pair_sel, dir_in}
  localparam logic [46:0] VEC [NVEC] = '{
    {3'd0, 32'h1234_5678, 4'h0, 8'h00},
    {3'd0, 32'hFEDC_BA98, 4'h5, 8'h3C},
    {3'd0, 32'h0F0F_A5C3, 4'hF, 8'hFF},
    {3'd1, 32'h9A3B_71E4, 4'h0, 8'h11},
    {3'd1, 32'h2C6D_8F05, 4'h5, 8'h22},
    {3'd1, 32'h7B1E_C4A9, 4'hA, 8'h44},
    {3'd2, 32'h0003_0005, 4'h0, 8'h00},
    {3'd2, 32'h000C_000A, 4'h9, 8'h81},
    {3'd2, 32'h0007_000E, 4'h6, 8'h18},
    {3'd3, 32'h6543_2106, 4'h3, 8'h00},
    {3'd3, 32'h3456_0615, 4'hC, 8'h00},
    {3'd3, 32'h7070_1717, 4'h7, 8'h00},
    {3'd4, 32'hA1B2_C3D4, 4'h1, 8'hF0},
    {3'd4, 32'h5E6F_7081, 4'h2, 8'h0F},
    {3'd4, 32'h13579_BDF, 4'hE, 8'hAA},
    {3'd4, 32'h2468_ACE0, 4'h8, 8'h55}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0;
  logic        cfg_din = 1'b0;
  logic [31:0] lut_in = '0;
  logic [3:0]  pair_sel = '0;
  logic [7:0]  dir_in = '0;
  logic [7:0]  cell_out;

  logic [CFG_W-1:0] cur = '0;
  logic [7:0]       mdl_q = '0;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  lut_cluster u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .lut_in(lut_in), .pair_sel(pair_sel), .dir_in(dir_in), .cell_out(cell_out)
  );

  function automatic logic [7:0] mdl_comb(logic [CFG_W-1:0] c, logic [31:0] li, logic [3:0] s);
    logic [7:0] lv, r;
    for (int i = 0; i < 8; i++) begin
      int src;
      src = i;
      if (c[OFF_SP + i/2] && (i % 2 == 1)) src = i - 1;
      if (c[OFF_SH + i/4]) src = (i / 4) * 4;
      lv[i] = c[i*16 + int'(li[src*4 +: 4])];
    end
    r = lv;
    for (int m = 0; m < 4; m++)
      if (c[OFF_FUSE + m]) r[2*m] = s[m] ? lv[2*m+1] : lv[2*m];
    for (int h = 0; h < 2; h++) begin
      if (c[OFF_WIDE + h]) begin
        logic p0, p1;
        p0 = s[2*h] ? lv[4*h+1] : lv[4*h];
        p1 = s[2*h] ? lv[4*h+3] : lv[4*h+2];
        r[4*h+3] = s[2*h+1] ? p1 : p0;
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] tt_rand(int i);
    logic [15:0] t;
    t = 16'((i + 1) * 40503);
    return t ^ 16'h5A3C ^ {t[7:0], t[15:8]};
  endfunction

  function automatic logic [15:0] tt_mux2();
    logic [15:0] t;
    for (int n = 0; n < 16; n++) t[n] = n[2] ? n[1] : n[0];
    return t;
  endfunction

  function automatic logic [CFG_W-1:0] mk_cfg(int id);
    logic [CFG_W-1:0] c;
    c = '0;
    for (int i = 0; i < 8; i++) c[i*16 +: 16] = (id == 3) ? tt_mux2() : tt_rand(i + id * 8);
    case (id)
      1: begin c[OFF_FUSE +: 4] = 4'b0101; c[OFF_SP +: 4] = 4'b0101; end
      2: begin c[OFF_SH +: 2] = 2'b11; c[OFF_WIDE +: 2] = 2'b11; c[OFF_FUSE +: 4] = 4'b1111; end
      3: c[OFF_WIDE +: 2] = 2'b11;
      4: begin
        c[OFF_FUSE +: 4] = 4'b0011;
        c[OFF_RS +: 8]   = 8'b1010_0110;
        c[OFF_FF +: 8]   = 8'b1100_0101;
      end
      default: ;
    endcase
    return c;
  endfunction

  function automatic string req_of(int id);
    case (id)
      0: return "R2";
      1: return "R3/R4/R5";
      2: return "R6";
      3: return "R7";
      default: return "R8/R9";
    endcase
  endfunction

  // reference flops
  always @(posedge clk) begin
    logic [7:0] cv, nx;
    cv = mdl_comb(cur, lut_in, pair_sel);
    for (int i = 0; i < 8; i++) nx[i] = cur[OFF_FF + i] ? dir_in[i] : cv[i];
    mdl_q <= rst ? 8'h00 : nx;
  end

  function automatic logic [7:0] exp_now();
    logic [7:0] rsel;
    rsel = cur[OFF_RS +: 8];
    return (mdl_q & rsel) | (mdl_comb(cur, lut_in, pair_sel) & ~rsel);
  endfunction

  task automatic chk(string req, logic [7:0] exp);
    n_run++;
    if (cell_out !== exp) begin
      n_fail++;
      $display("FAIL %s: cell_out=%h expected %h", req, cell_out, exp);
    end
  endtask

  task automatic load(logic [CFG_W-1:0] v);
    cur = v;
    for (int b = CFG_W - 1; b >= 0; b--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = v[b];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    rst    = 1'b1;
    @(negedge clk);
    rst    = 1'b0;
  endtask

  task automatic apply(logic [31:0] li, logic [3:0] s, logic [7:0] d);
    @(negedge clk);
    lut_in = li; pair_sel = s; dir_in = d;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cur_id;
    logic [CFG_W-1:0] sp;
    logic [7:0] cv;

    // R1: sparse load checks bit placement (first load stays under reset)
    sp = '0;
    sp[0] = 1'b1;
    sp[OFF_FF + 7] = 1'b1;
    sp[OFF_RS + 7] = 1'b1;
    load(sp);
    apply(32'h0, 4'h0, 8'h80);
    chk("R1", 8'h01);
    apply(32'h0, 4'h0, 8'h80);
    chk("R1", 8'h81);

    // table walk
    cur_id = -1;
    for (int v = 0; v < NVEC; v++) begin
      int id;
      id = int'(VEC[v][46:44]);
      if (id != cur_id) begin
        load(mk_cfg(id));
        cur_id = id;
      end
      apply(VEC[v][43:12], VEC[v][11:8], VEC[v][7:0]);
      chk(req_of(id), exp_now());
    end

    // R1: cfg_din toggling with cfg_en low leaves config unchanged
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_din = k[0];
    end
    apply(32'h1357_9BDF, 4'h6, 8'h5A);
    chk("R1", exp_now());

    // R10: reset clears flops only
    apply(32'hFFFF_FFFF, 4'hF, 8'hFF);
    apply(32'hFFFF_FFFF, 4'hF, 8'hFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    cv = mdl_comb(cur, lut_in, pair_sel);
    chk("R10", cv & ~8'b1010_0110);
    rst = 1'b0;
    apply(32'h0246_8ACE, 4'h3, 8'h0F);
    chk("R10", exp_now());

    // R7: directed 8-to-1 pick, LUT2 selected and returning 1
    load(mk_cfg(3));
    apply(32'h0000_0600, 4'h2, 8'h00);
    chk("R7", 8'h0C);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule